// File: doc/BRIEF.md
# Product-Term Macrocell Function Block

This block is one logic cell array of a small complex programmable device. A shared input bus is expanded into true and inverted literals. Every product term is a programmable AND over any subset of those literals. Each macrocell owns a fixed group of product terms. A steering field on every term either keeps the term at home, lends it to the macrocell just below or just above, or switches it off. This lets one output build a wider sum than its own group allows. The resulting sum passes through a polarity XOR. It then leaves either directly or through a flip-flop that has a programmable preset value.

All programming is shifted in one bit per clock while a load strobe is high. Until a load has finished, every output enable stays low. After that, each output drives only when its own enable bit and the shared output-enable input are both high. A shared set/reset input loads every macrocell flip-flop with its programmed preset value.

Top module: `fb_sop_block`

## Requirements
- R1: After reset, all output enables are low until a configuration load has completed, which is the first clock edge with `cfg_en` low after at least one shift. The enables are also low from the clock edge after any edge at which `cfg_en` is high.
- R2: A product term is the AND of its selected literals. Select bit 2k picks input k true, and bit 2k+1 picks input k inverted. A term with nothing selected is 1. A term that selects both forms of the same input is 0.
- R3: A macrocell's sum is the OR of its own terms whose steer code is 0.
- R4: Steer code 1 moves a term into the sum of macrocell m-1, and code 2 moves it into macrocell m+1. Code 3 disables the term. A term steered away, or off the end of the array, adds 0 to its home sum.
- R5: When the polarity bit is set, the sum is inverted before the output stage.
- R6: In registered mode the output is the flip-flop, which takes the polarity-adjusted sum at each clock edge once loading is complete. In combinational mode the output follows the inputs with no clock.
- R7: While `gsr` is high at a clock edge, every macrocell flip-flop takes its programmed preset value, whatever its data input is.
- R8: `mc_oe[m]` is high only when the load is complete, `gbl_oe` is high and macrocell m's enable bit is set.
- R9: Configuration layout: the bit shifted in last lands at image bit 0. Macrocell m occupies bits m*MC_W upward, with MC_W = N_PT*(2*N_IN+2)+4. Within that range, term p starts at p*(2*N_IN+2) and holds 2*N_IN select bits followed by a 2-bit steer code. After the terms come the polarity, registered-mode, preset and enable bits, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Configuration shift strobe |
| cfg_din | input | 1 | Serial configuration data |
| gsr | input | 1 | Global set/reset to programmed preset values |
| gbl_oe | input | 1 | Global output enable |
| din | input | N_IN | Shared logic inputs |
| mc_out | output | N_MC | Macrocell output values |
| mc_oe | output | N_MC | Macrocell three-state enables |

## Verification
The hardest case to reach from the ports is a term that leaves its home macrocell: one lent to a neighbour, one switched off, or one lent past the array edge. The leak only shows up if such a term would otherwise change its home output. The stimulus therefore programs these moved terms to be always-true, so a leak forces the output constant. It also gives the receiving neighbour a sum whose truth table differs when the borrowed term is present. It then sweeps every input combination. Two complete images are loaded in turn, so that both steer directions, the disable code and the enable bit are each seen in two states.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {
    STEER_HOME = 2'd0,
    STEER_DOWN = 2'd1,
    STEER_UP   = 2'd2,
    STEER_OFF  = 2'd3
  } steer_e;
endpackage

// File: rtl/fb_pterm_array.sv
module fb_pterm_array #(
  parameter int N_IN   = 36,
  parameter int N_TERM = 90
) (
  input  logic [N_IN-1:0]          din,
  input  logic [N_TERM*2*N_IN-1:0] sel,
  output logic [N_TERM-1:0]        pt
);
  localparam int LW = 2 * N_IN;

  logic [LW-1:0] lit;

  always_comb begin
    for (int k = 0; k < N_IN; k++) begin
      lit[2*k]   = din[k];
      lit[2*k+1] = ~din[k];
    end
  end

  // unselected literals read as 1, so an empty term is 1
  generate
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
      assign pt[t] = &(~sel[t*LW +: LW] | lit);
    end
  endgenerate
endmodule

// File: rtl/fb_term_allocator.sv
module fb_term_allocator
  import fb_pkg::*;
#(
  parameter int N_MC = 18,
  parameter int N_PT = 5
) (
  input  logic [N_MC*N_PT-1:0]   pt,
  input  logic [N_MC*N_PT*2-1:0] steer,
  output logic [N_MC-1:0]        sum
);
  always_comb begin
    sum = '0;
    for (int m = 0; m < N_MC; m++) begin
      for (int p = 0; p < N_PT; p++) begin
        case (steer_e'(steer[2*(m*N_PT+p) +: 2]))
          STEER_HOME: sum[m] = sum[m] | pt[m*N_PT+p];
          STEER_DOWN: if (m > 0)        sum[m-1] = sum[m-1] | pt[m*N_PT+p];
          STEER_UP:   if (m < N_MC - 1) sum[m+1] = sum[m+1] | pt[m*N_PT+p];
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fb_macrocell.sv
module fb_macrocell (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic gsr,
  input  logic sum,
  input  logic pol,
  input  logic reg_mode,
  input  logic init_val,
  output logic d_o,
  output logic q_o,
  output logic out
);
  logic q_next;

  assign d_o = sum ^ pol;

  always_comb begin
    q_next = q_o;
    if (gsr)     q_next = init_val;
    else if (ce) q_next = d_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_next;
  end

  assign out = reg_mode ? q_o : d_o;
endmodule

// File: rtl/fb_sop_block.sv
module fb_sop_block #(
  parameter int N_IN = 36,
  parameter int N_MC = 18,
  parameter int N_PT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic            gsr,
  input  logic            gbl_oe,
  input  logic [N_IN-1:0] din,
  output logic [N_MC-1:0] mc_out,
  output logic [N_MC-1:0] mc_oe
);
  localparam int LW     = 2 * N_IN;
  localparam int PT_W   = LW + 2;
  localparam int MC_W   = N_PT * PT_W + 4;
  localparam int CFG_W  = N_MC * MC_W;
  localparam int N_TERM = N_MC * N_PT;

  // reset synchronizer
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // configuration shift chain (datapath, no reset)
  logic [CFG_W-1:0] chain, chain_next;
  always_comb begin
    chain_next = chain;
    if (cfg_en) chain_next = {chain[CFG_W-2:0], cfg_din};
  end
  always_ff @(posedge clk) chain <= chain_next;

  // load completion tracking
  logic armed, armed_next, cfg_valid, valid_next;
  always_comb begin
    armed_next = armed | cfg_en;
    valid_next = armed & ~cfg_en;
  end
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      armed     <= 1'b0;
      cfg_valid <= 1'b0;
    end else begin
      armed     <= armed_next;
      cfg_valid <= valid_next;
    end
  end

  // field extraction
  logic [N_TERM*LW-1:0] sel_vec;
  logic [N_TERM*2-1:0]  steer_vec;
  logic [N_MC-1:0]      pol_vec, reg_vec, init_vec, oe_vec;

  generate
    for (genvar m = 0; m < N_MC; m++) begin : g_fld
      for (genvar p = 0; p < N_PT; p++) begin : g_pt
        assign sel_vec[(m*N_PT+p)*LW +: LW]  = chain[m*MC_W + p*PT_W +: LW];
        assign steer_vec[(m*N_PT+p)*2 +: 2]  = chain[m*MC_W + p*PT_W + LW +: 2];
      end
      assign pol_vec[m]  = chain[m*MC_W + N_PT*PT_W];
      assign reg_vec[m]  = chain[m*MC_W + N_PT*PT_W + 1];
      assign init_vec[m] = chain[m*MC_W + N_PT*PT_W + 2];
      assign oe_vec[m]   = chain[m*MC_W + N_PT*PT_W + 3];
    end
  endgenerate

  logic [N_TERM-1:0] pt;
  logic [N_MC-1:0]   sum, mc_d, mc_q;

  fb_pterm_array #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .din (din),
    .sel (sel_vec),
    .pt  (pt)
  );

  fb_term_allocator #(.N_MC(N_MC), .N_PT(N_PT)) u_alloc (
    .pt    (pt),
    .steer (steer_vec),
    .sum   (sum)
  );

  generate
    for (genvar m = 0; m < N_MC; m++) begin : g_mc
      fb_macrocell u_mc (
        .clk      (clk),
        .rst_n    (rst_q_n),
        .ce       (cfg_valid),
        .gsr      (gsr),
        .sum      (sum[m]),
        .pol      (pol_vec[m]),
        .reg_mode (reg_vec[m]),
        .init_val (init_vec[m]),
        .d_o      (mc_d[m]),
        .q_o      (mc_q[m]),
        .out      (mc_out[m])
      );
    end
  endgenerate

  assign mc_oe = oe_vec & {N_MC{cfg_valid & gbl_oe}};
endmodule

// File: rtl/fb_sop_checker.sv
module fb_sop_checker #(
  parameter int N_MC = 18
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            cfg_en,
  input logic            gbl_oe,
  input logic            gsr,
  input logic            cfg_valid,
  input logic [N_MC-1:0] mc_oe,
  input logic [N_MC-1:0] mc_q,
  input logic [N_MC-1:0] mc_d,
  input logic [N_MC-1:0] init_vec
);
  // R1
  oe_quiet_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_en |=> (mc_oe == '0));

  // R1
  oe_quiet_unloaded_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cfg_valid |-> (mc_oe == '0));

  // R8
  oe_global_gate_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !gbl_oe |-> (mc_oe == '0));

  // R7
  gsr_preset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gsr && cfg_valid && !cfg_en) |=> (mc_q == $past(init_vec)));

  // R6
  reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!gsr && cfg_valid) |=> (mc_q == $past(mc_d)));
endmodule

bind fb_sop_block fb_sop_checker #(.N_MC(N_MC)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .cfg_en    (cfg_en),
  .gbl_oe    (gbl_oe),
  .gsr       (gsr),
  .cfg_valid (cfg_valid),
  .mc_oe     (mc_oe),
  .mc_q      (mc_q),
  .mc_d      (mc_d),
  .init_vec  (init_vec)
);

// File: tb/sim_fb_sop_block.sv
module sim_fb_sop_block;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 4;
  localparam int N_MC = 3;
  localparam int N_PT = 2;
  localparam int LW   = 2 * N_IN;
  localparam int PT_W = LW + 2;
  localparam int MC_W = N_PT * PT_W + 4;
  localparam int W    = N_MC * MC_W;

  logic            clk = 1'b0;
  logic            rst_n, cfg_en, cfg_din, gsr, gbl_oe;
  logic [N_IN-1:0] din;
  logic [N_MC-1:0] mc_out, mc_oe;
  logic [W-1:0]    img;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_sop_block #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .gsr(gsr), .gbl_oe(gbl_oe), .din(din), .mc_out(mc_out), .mc_oe(mc_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_term(input int m, input int p, input logic [LW-1:0] s, input logic [1:0] st);
    img[m*MC_W + p*PT_W +: LW]  = s;
    img[m*MC_W + p*PT_W + LW +: 2] = st;
  endtask

  task automatic set_mc(input int m, input logic pol, input logic rg, input logic ini, input logic oe);
    img[m*MC_W + N_PT*PT_W +: 4] = {oe, ini, rg, pol};
  endtask

  // R9: last bit shifted lands at image bit 0
  task automatic load_image();
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      cfg_din = img[i];
      @(negedge clk);
      if (i == W / 2) chk("R1 oe low while loading", 32'(mc_oe), 32'h0);
    end
    cfg_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; gsr = 1'b0; gbl_oe = 1'b1; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe low before any load", 32'(mc_oe), 32'h0);
  endtask

  task automatic t_image_a();
    img = '0;
    set_term(0, 0, 8'h09, 2'd0);  // x0 & ~x1
    set_term(0, 1, 8'h10, 2'd0);  // x2
    set_mc(0, 1'b0, 1'b0, 1'b0, 1'b1);
    set_term(1, 0, 8'h40, 2'd1);  // x3 lent down to macrocell 0
    set_term(1, 1, 8'h03, 2'd0);  // x0 & ~x0
    set_mc(1, 1'b1, 1'b0, 1'b0, 1'b1);
    set_term(2, 0, 8'h00, 2'd2);  // always-true, lent off the top edge
    set_term(2, 1, 8'h04, 2'd0);  // x1
    set_mc(2, 1'b0, 1'b1, 1'b1, 1'b1);
    load_image();
    chk("R8 oe after load A", 32'(mc_oe), 32'h7);
  endtask

  task automatic t_comb_a();
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      din = 4'(v);
      #1;
      chk("R2 R3 R4 out0 sum with borrowed term", 32'(mc_out[0]),
          32'((din[0] & ~din[1]) | din[2] | din[3]));
      chk("R4 R5 out1 lent and contradictory terms", 32'(mc_out[1]), 32'h1);
    end
  endtask

  task automatic t_registered();
    @(negedge clk); din = 4'b0010;
    @(negedge clk);
    chk("R6 registered captures 1", 32'(mc_out[2]), 32'h1);
    din = 4'b0000;
    #1;
    chk("R6 registered holds between edges", 32'(mc_out[2]), 32'h1);
    @(negedge clk);
    chk("R6 registered captures 0", 32'(mc_out[2]), 32'h0);
    gsr = 1'b1;
    @(negedge clk);
    chk("R7 gsr forces preset over data", 32'(mc_out[2]), 32'h1);
    gsr = 1'b0;
    @(negedge clk);
    chk("R6 capture resumes after gsr", 32'(mc_out[2]), 32'h0);
  endtask

  task automatic t_global_oe();
    @(negedge clk); gbl_oe = 1'b0; #1;
    chk("R8 global oe low", 32'(mc_oe), 32'h0);
    gbl_oe = 1'b1; #1;
    chk("R8 global oe high", 32'(mc_oe), 32'h7);
  endtask

  task automatic t_image_b();
    img = '0;
    set_term(0, 0, 8'h40, 2'd2);  // x3 lent up to macrocell 1
    set_term(0, 1, 8'h00, 2'd3);  // always-true, disabled
    set_mc(0, 1'b1, 1'b0, 1'b0, 1'b1);
    set_term(1, 0, 8'h10, 2'd0);  // x2
    set_term(1, 1, 8'h0C, 2'd0);  // x1 & ~x1
    set_mc(1, 1'b0, 1'b0, 1'b0, 1'b0);
    set_term(2, 0, 8'h08, 2'd0);  // ~x1
    set_term(2, 1, 8'h00, 2'd3);
    set_mc(2, 1'b1, 1'b0, 1'b0, 1'b1);
    load_image();
    chk("R8 per-macrocell enable bit", 32'(mc_oe), 32'h5);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      din = 4'(v);
      #1;
      chk("R4 R5 out0 disabled and lent terms", 32'(mc_out[0]), 32'h1);
      chk("R3 R4 out1 borrowed from below", 32'(mc_out[1]), 32'(din[2] | din[3]));
      chk("R2 R5 out2 inverted literal", 32'(mc_out[2]), 32'(din[1]));
    end
  endtask

  initial begin
    t_reset();
    t_image_a();
    t_comb_a();
    t_registered();
    t_global_oe();
    t_image_b();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule